// File: doc/BRIEF.md
# External Memory Access Sequencer

This block sits between a processor core and its external memory pins. The core presents one external access at a time: a segment code, a direction, an address and write data. The block puts the address on a single shared 16-bit address bus and raises exactly one of four segment strobes: instruction/coefficient ROM, low RAM, I/O or high RAM. For a write it also raises a write strobe and drives the data bus. Accesses are served strictly in the order they are accepted. Each access lasts one cycle plus the number of wait states held for its segment. The core is held off through `core_ready` while an access is being stretched.

Two configuration bits change where data accesses go. The redirect bit sends every low-RAM, I/O and high-RAM access to the ROM strobe, so that the ROM can be written. If the alias bit is also set, the top address bit is forced low, so the upper half of the address space folds onto the lower half. A third bit delays the leading edge of the strobe in the first cycle of each access until the falling clock edge. This leaves a half-cycle gap in which no two devices drive the data bus. Between accesses the address bus keeps the last external address, and the bus is released while reset is held.

The controller is a three-state machine. `ST_IDLE` means no access. `ST_STRETCH` is a wait-state cycle with more cycles to follow. `ST_FINAL` is the last cycle of an access. The transitions are: idle-to-final (request with zero waits), idle-to-stretch (request with waits), stretch-to-stretch (count above one), stretch-to-final (count reaches one), final-to-final or final-to-stretch (a back-to-back request), and final-to-idle (no request).

Top module: `ext_mem_seq`

## Requirements
- R1: A request is accepted on a rising edge where `core_req` and `core_ready` are both high. Accesses are served in order, one at a time. With zero wait states, consecutive requests run back to back, one per cycle.
- R2: An access lasts 1+W cycles. W is the 4-bit field `cfg_wait[4*s+3:4*s]` of the segment `s` whose strobe is asserted, with segment codes ROM=0, low RAM=1, I/O=2, high RAM=3. `core_ready` is low in all but the last cycle of the access.
- R3: During an access exactly one strobe (`sel_rom`, `sel_ramlo`, `sel_io`, `sel_ramhi`) is high: the one selected by `core_seg` at acceptance. With no access in progress, all strobes are low.
- R4: While `cfg_rom_redirect` is 1, every accepted access asserts `sel_rom` and uses the ROM wait field, whatever its segment code.
- R5: While both `cfg_rom_redirect` and `cfg_alias_high` are 1, bit 15 of `mem_addr` is 0 for the accepted access. With `cfg_alias_high` alone set, the address passes unchanged.
- R6: `mem_addr` is loaded only when an access is accepted and holds its value at all other times.
- R7: `mem_addr_oe` is low while `rst_n` is low. It goes high at the first rising edge after `rst_n` is released.
- R8: `mem_we` and `mem_dout_oe` are high exactly while the strobe of a write access is high, and both drop with it (zero hold). `mem_dout` then carries the accepted write data.
- R9: With `cfg_late_edge` set, the strobe, `mem_we` and `mem_dout_oe` stay low in the first half of the first cycle of each access and rise at the falling clock edge. This also holds between back-to-back accesses.
- R10: For a read, `core_rvalid` is high for one cycle after the last cycle of the access. `core_rdata` then holds `mem_din` as sampled at the rising edge that ended the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobe delay uses the falling edge |
| rst_n | input | 1 | Active-low reset |
| cfg_rom_redirect | input | 1 | Send data-space accesses to the ROM strobe |
| cfg_alias_high | input | 1 | With redirect, force address bit 15 low |
| cfg_late_edge | input | 1 | Delay strobe leading edge by half a cycle |
| cfg_wait | input | 16 | Four 4-bit wait-state fields, one per segment |
| core_req | input | 1 | Core requests an external access |
| core_seg | input | 2 | Segment code of the request |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 16 | Access address |
| core_wdata | input | 16 | Write data |
| core_ready | output | 1 | Request may be accepted at next rising edge |
| core_rvalid | output | 1 | Read data valid pulse |
| core_rdata | output | 16 | Read data |
| mem_addr | output | 16 | External address bus |
| mem_addr_oe | output | 1 | Address bus drive enable |
| mem_dout | output | 16 | External data bus, outgoing |
| mem_dout_oe | output | 1 | Data bus drive enable |
| mem_din | input | 16 | External data bus, incoming |
| sel_rom | output | 1 | ROM segment strobe |
| sel_ramlo | output | 1 | Low RAM segment strobe |
| sel_io | output | 1 | I/O segment strobe |
| sel_ramhi | output | 1 | High RAM segment strobe |
| mem_we | output | 1 | Write strobe |

## Verification
On every rising edge, the assertions check the following. At most one strobe is high. The data bus is driven only under a single strobe. The address holds between acceptances. A redirected or aliased acceptance lands on the ROM strobe with bit 15 clear. The wait counter never sits at zero in a stretch cycle. The half-cycle delay of the leading edge, the exact length of each access for each wait field, the order of back-to-back accesses, the read data path and the bus release in reset are only shown by the bench scenarios. There, a behavioural model is compared at both phases of every clock.

// File: rtl/xms_pkg.sv
package xms_pkg;
    localparam int NSEG = 4;

    typedef enum logic [1:0] {
        SEG_ROM   = 2'd0,
        SEG_RAMLO = 2'd1,
        SEG_IO    = 2'd2,
        SEG_RAMHI = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_FINAL   = 2'd2
    } st_e;
endpackage

// File: rtl/xms_route.sv
module xms_route
    import xms_pkg::*;
#(
    parameter int AW  = 16,
    parameter int WSW = 4
) (
    input  logic                 redirect,
    input  logic                 alias_high,
    input  logic [NSEG*WSW-1:0]  wait_cfg,
    input  seg_e                 seg_in,
    input  logic [AW-1:0]        addr_in,
    output seg_e                 seg_out,
    output logic [AW-1:0]        addr_out,
    output logic [WSW-1:0]       waits
);
    logic [WSW-1:0] fld [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_fld
        assign fld[g] = wait_cfg[g*WSW +: WSW];
    end

    always_comb begin
        seg_out  = redirect ? SEG_ROM : seg_in;
        addr_out = addr_in;
        if (redirect && alias_high) begin
            addr_out[AW-1] = 1'b0;
        end
        waits = fld[seg_out];
    end
endmodule

// File: rtl/xms_ctrl.sv
module xms_ctrl
    import xms_pkg::*;
#(
    parameter int WSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic [WSW-1:0] waits,
    output logic           ready,
    output logic           take,
    output logic           active,
    output logic           last,
    output logic           tog
);
    st_e            st, st_nx;
    logic [WSW-1:0] cnt;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (req) st_nx = (waits == '0) ? ST_FINAL : ST_STRETCH;
            end
            ST_STRETCH: begin
                if (cnt == WSW'(1)) st_nx = ST_FINAL;
            end
            ST_FINAL: begin
                if (req) st_nx = (waits == '0) ? ST_FINAL : ST_STRETCH;
                else     st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            tog <= 1'b0;
        end else begin
            st <= st_nx;
            if (take) begin
                cnt <= waits;
                tog <= ~tog;
            end else if (st == ST_STRETCH) begin
                cnt <= cnt - WSW'(1);
            end
        end
    end

    always_comb begin
        ready  = (st != ST_STRETCH);
        take   = ready && req;
        active = (st != ST_IDLE);
        last   = (st == ST_FINAL);
    end

    // R2
    stretch_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STRETCH) |-> (cnt != '0));

    // R2
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STRETCH && cnt > WSW'(1)) |=> (st == ST_STRETCH && !ready));

    // R1
    final_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FINAL && !req) |=> (st == ST_IDLE));
endmodule

// File: rtl/xms_pins.sv
module xms_pins
    import xms_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  seg_e            seg,
    input  logic            we,
    input  logic [DW-1:0]   wdata,
    input  logic            late,
    input  logic            tog,
    output logic [NSEG-1:0] sel,
    output logic            wr_strb,
    output logic [DW-1:0]   dout,
    output logic            dout_oe
);
    logic neg_tog;
    logic hold_off;
    logic vis;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_tog <= 1'b0;
        else        neg_tog <= tog;
    end

    always_comb begin
        hold_off = late && (tog != neg_tog);
        vis      = active && !hold_off;
        wr_strb  = vis && we;
        dout_oe  = wr_strb;
        dout     = dout_oe ? wdata : '0;
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_sel
        assign sel[i] = vis && (seg == seg_e'(i));
    end

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R8
    dout_under_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> ($countones(sel) == 1));
endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
    import xms_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int WSW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_rom_redirect,
    input  logic                cfg_alias_high,
    input  logic                cfg_late_edge,
    input  logic [4*WSW-1:0]    cfg_wait,
    input  logic                core_req,
    input  logic [1:0]          core_seg,
    input  logic                core_we,
    input  logic [AW-1:0]       core_addr,
    input  logic [DW-1:0]       core_wdata,
    output logic                core_ready,
    output logic                core_rvalid,
    output logic [DW-1:0]       core_rdata,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_addr_oe,
    output logic [DW-1:0]       mem_dout,
    output logic                mem_dout_oe,
    input  logic [DW-1:0]       mem_din,
    output logic                sel_rom,
    output logic                sel_ramlo,
    output logic                sel_io,
    output logic                sel_ramhi,
    output logic                mem_we
);
    seg_e           r_seg;
    logic [AW-1:0]  r_addr;
    logic [WSW-1:0] r_waits;
    logic           take, active, last, tog;
    seg_e           a_seg;
    logic           a_we;
    logic [DW-1:0]  a_wdata;
    logic [NSEG-1:0] sel;

    xms_route #(.AW(AW), .WSW(WSW)) u_route (
        .redirect   (cfg_rom_redirect),
        .alias_high (cfg_alias_high),
        .wait_cfg   (cfg_wait),
        .seg_in     (seg_e'(core_seg)),
        .addr_in    (core_addr),
        .seg_out    (r_seg),
        .addr_out   (r_addr),
        .waits      (r_waits)
    );

    xms_ctrl #(.WSW(WSW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (core_req),
        .waits  (r_waits),
        .ready  (core_ready),
        .take   (take),
        .active (active),
        .last   (last),
        .tog    (tog)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_seg       <= SEG_ROM;
            a_we        <= 1'b0;
            a_wdata     <= '0;
            mem_addr    <= '0;
            mem_addr_oe <= 1'b0;
            core_rvalid <= 1'b0;
            core_rdata  <= '0;
        end else begin
            mem_addr_oe <= 1'b1;
            core_rvalid <= last && !a_we;
            if (last && !a_we) core_rdata <= mem_din;
            if (take) begin
                a_seg    <= r_seg;
                a_we     <= core_we;
                a_wdata  <= core_wdata;
                mem_addr <= r_addr;
            end
        end
    end

    xms_pins #(.DW(DW)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .seg     (a_seg),
        .we      (a_we),
        .wdata   (a_wdata),
        .late    (cfg_late_edge),
        .tog     (tog),
        .sel     (sel),
        .wr_strb (mem_we),
        .dout    (mem_dout),
        .dout_oe (mem_dout_oe)
    );

    assign sel_rom   = sel[SEG_ROM];
    assign sel_ramlo = sel[SEG_RAMLO];
    assign sel_io    = sel[SEG_IO];
    assign sel_ramhi = sel[SEG_RAMHI];

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(mem_addr));

    // R5
    alias_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cfg_rom_redirect && cfg_alias_high) |=> !mem_addr[AW-1]);

    // R4
    redirect_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cfg_rom_redirect) |=> (sel_rom && !sel_ramlo && !sel_io && !sel_ramhi));
endmodule

// File: tb/test_ext_mem_seq.sv
module test_ext_mem_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rom_redirect = 1'b0;
    logic        cfg_alias_high = 1'b0;
    logic        cfg_late_edge = 1'b0;
    logic [15:0] cfg_wait = 16'h0000;
    logic        core_req = 1'b0;
    logic [1:0]  core_seg = 2'd0;
    logic        core_we = 1'b0;
    logic [15:0] core_addr = 16'h0000;
    logic [15:0] core_wdata = 16'h0000;
    logic        core_ready, core_rvalid;
    logic [15:0] core_rdata, mem_addr, mem_dout, mem_din;
    logic        mem_addr_oe, mem_dout_oe, mem_we;
    logic        sel_rom, sel_ramlo, sel_io, sel_ramhi;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign mem_din = mem_addr ^ 16'h5A5A;

    ext_mem_seq i_ext_mem_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_rom_redirect(cfg_rom_redirect), .cfg_alias_high(cfg_alias_high),
        .cfg_late_edge(cfg_late_edge), .cfg_wait(cfg_wait),
        .core_req(core_req), .core_seg(core_seg), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_ready(core_ready), .core_rvalid(core_rvalid), .core_rdata(core_rdata),
        .mem_addr(mem_addr), .mem_addr_oe(mem_addr_oe),
        .mem_dout(mem_dout), .mem_dout_oe(mem_dout_oe), .mem_din(mem_din),
        .sel_rom(sel_rom), .sel_ramlo(sel_ramlo), .sel_io(sel_io),
        .sel_ramhi(sel_ramhi), .mem_we(mem_we)
    );

    // behavioural reference state
    int          m_rem = 0;
    int          m_seg = 0;
    bit          m_we = 0;
    bit          m_new = 0;
    bit          m_oe = 0;
    bit          m_rdv = 0;
    bit          m_redir = 0;
    bit          m_alias = 0;
    logic [15:0] m_addr = 0;
    logic [15:0] m_wdata = 0;
    logic [15:0] m_rdd = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_sel(input bit full);
        logic [3:0] v;
        v = '0;
        if (m_rem > 0 && (full || !(cfg_late_edge && m_new))) v[m_seg] = 1'b1;
        return v;
    endfunction

    always begin
        @(posedge clk);
        if (!rst_n) begin
            m_rem = 0; m_oe = 0; m_rdv = 0; m_new = 0; m_we = 0; m_seg = 0;
            m_addr = 0; m_rdd = 0;
        end else begin
            bit rdy;
            m_oe = 1;
            m_rdv = (m_rem == 1) && !m_we;
            if (m_rdv) m_rdd = m_addr ^ 16'h5A5A;
            rdy = (m_rem <= 1);
            if (m_rem > 0) m_rem--;
            m_new = 0;
            if (rdy && core_req) begin
                m_redir = cfg_rom_redirect;
                m_alias = cfg_rom_redirect && cfg_alias_high;
                m_seg   = cfg_rom_redirect ? 0 : int'(core_seg);
                m_addr  = core_addr;
                if (m_alias) m_addr[15] = 1'b0;
                m_we    = core_we;
                m_wdata = core_wdata;
                m_rem   = int'(cfg_wait[m_seg*4 +: 4]) + 1;
                m_new   = 1;
            end
        end
        #5;
        begin
            logic [3:0] s;
            string st;
            s = {sel_ramhi, sel_io, sel_ramlo, sel_rom};
            chk(mem_addr_oe == m_oe, "R7 addr_oe", 32'(mem_addr_oe), 32'(m_oe));
            if (m_oe) begin
                chk(core_ready == (m_rem <= 1), (m_rem > 1) ? "R2 ready" : "R1 ready",
                    32'(core_ready), 32'(m_rem <= 1));
                st = m_alias ? "R5 addr" : "R6 addr";
                chk(mem_addr == m_addr, st, 32'(mem_addr), 32'(m_addr));
                st = (cfg_late_edge && m_new) ? "R9 sel early" : (m_redir ? "R4 sel" : "R3 sel");
                chk(s == exp_sel(0), st, 32'(s), 32'(exp_sel(0)));
                chk(mem_we == (exp_sel(0) != 0 && m_we), "R8 we early",
                    32'(mem_we), 32'(exp_sel(0) != 0 && m_we));
                chk(mem_dout_oe == mem_we, "R8 dout_oe", 32'(mem_dout_oe), 32'(mem_we));
                if (mem_dout_oe) chk(mem_dout == m_wdata, "R8 dout", 32'(mem_dout), 32'(m_wdata));
                chk(core_rvalid == m_rdv, "R10 rvalid", 32'(core_rvalid), 32'(m_rdv));
                if (m_rdv) chk(core_rdata == m_rdd, "R10 rdata", 32'(core_rdata), 32'(m_rdd));
            end
        end
        #10;
        if (m_oe) begin
            logic [3:0] s2;
            s2 = {sel_ramhi, sel_io, sel_ramlo, sel_rom};
            chk(s2 == exp_sel(1), m_redir ? "R4 sel late" : "R3 sel late",
                32'(s2), 32'(exp_sel(1)));
            chk(mem_we == (m_rem > 0 && m_we), "R8 we late",
                32'(mem_we), 32'(m_rem > 0 && m_we));
        end
    end

    // called at 15 ns after a rising edge; returns at the same phase after acceptance
    task automatic access(input logic [1:0] seg, input bit we, input logic [15:0] a,
                          input logic [15:0] d);
        bit rdy;
        core_req = 1; core_seg = seg; core_we = we; core_addr = a; core_wdata = d;
        rdy = core_ready;
        @(posedge clk);
        while (!rdy) begin
            #15; rdy = core_ready;
            @(posedge clk);
        end
        #15;
    endtask

    task automatic idle(input int n);
        core_req = 0;
        repeat (n) @(posedge clk);
        #15;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #15;
        rst_n = 1;
        idle(2);
        // R1: four back-to-back accesses, zero waits
        access(2'd0, 0, 16'h0100, 16'h0);
        access(2'd1, 1, 16'h0200, 16'hBEEF);
        access(2'd0, 0, 16'h0101, 16'h0);
        access(2'd1, 0, 16'h0200, 16'h0);
        idle(3);
        // R2: per-segment wait fields
        cfg_wait = 16'h3210;
        access(2'd0, 0, 16'h1000, 16'h0);
        access(2'd1, 1, 16'h1100, 16'h1234);
        access(2'd2, 0, 16'h1200, 16'h0);
        access(2'd3, 1, 16'hC300, 16'h4321);
        idle(4);
        access(2'd3, 0, 16'hF00F, 16'h0);
        idle(5);
        // R4: redirect to ROM strobe, ROM field used
        cfg_wait = 16'h5551;
        cfg_rom_redirect = 1;
        access(2'd1, 1, 16'h8001, 16'hAAAA);
        access(2'd2, 0, 16'h9002, 16'h0);
        idle(3);
        // R5: alias with redirect
        cfg_alias_high = 1;
        access(2'd3, 1, 16'h9234, 16'h5555);
        access(2'd1, 0, 16'hFFFF, 16'h0);
        idle(3);
        // R5: alias alone passes address
        cfg_rom_redirect = 0;
        access(2'd3, 0, 16'hA5A5, 16'h0);
        idle(3);
        // R9: late leading edge, back to back and stretched
        cfg_alias_high = 0;
        cfg_late_edge = 1;
        cfg_wait = 16'h0200;
        access(2'd1, 1, 16'h0042, 16'h7777);
        access(2'd0, 0, 16'h0043, 16'h0);
        access(2'd2, 1, 16'h0044, 16'h8888);
        access(2'd3, 0, 16'h0045, 16'h0);
        idle(4);
        cfg_late_edge = 0;
        // R7: reset during an access
        cfg_wait = 16'hFFFF;
        core_req = 1; core_seg = 2'd2; core_we = 0; core_addr = 16'h3333;
        @(posedge clk); #15;
        core_req = 0;
        repeat (3) @(posedge clk);
        #15;
        rst_n = 0;
        idle(3);
        rst_n = 1;
        idle(3);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule